// File: doc/BRIEF.md
# Masked Pattern-Match Interrupt Detector

This block watches a group of port lines and raises one interrupt request when a programmed condition on those lines becomes true. Each line is taken either from its pin (input-direction lines) or from the port's own output register (output-direction lines). A mask picks which lines take part, a polarity bit picks the level that counts as active, and a combine select asks either that every monitored line be active or that at least one be.

The request follows the condition's false-to-true transitions, not its level. A rise sets a pending flag. The enable gates that flag onto the registered request output. A clear pulse drops the flag. While the processor's fetch-cycle sync signal is asserted, the output holds its value. Any change that arrives in that time shows at the first clock edge after the sync signal falls.

Top module: `pattern_irq_detect`

## Requirements
- R1: A line whose `mask` bit is 1 is excluded from the condition. Changes on that line never raise a request.
- R2: With `all_mode`=1, the condition is true only when every unmasked line is at the active level.
- R3: With `all_mode`=0, the condition is true when at least one unmasked line is at the active level.
- R4: `level_high`=1 makes logic 1 the active level. `level_high`=0 makes logic 0 the active level.
- R5: A request is raised only on a false-to-true change of the condition. A condition that stays true raises nothing further, and neither does another line going active while it is true.
- R6: A line whose `dir_in` bit is 0 is evaluated from `out_val`, and its pin value is ignored. A `dir_in` bit of 1 selects the pin.
- R7: When all mask bits are 1, the condition is false in both combine modes, so no request is ever raised.
- R8: While `sync_fetch` is 1, `irq_req` keeps its value. A rise or a clear that happens during that time appears at the first clock edge sampled with `sync_fetch`=0.
- R9: A `clr_pend` pulse drops an outstanding request at the next edge. A clear wins over a simultaneous rise. A condition that is still true does not re-raise the request until it has gone false and then true again.
- R10: With `irq_en`=0, `irq_req` is 0 while a detected rise stays pending. Setting `irq_en` to 1 then drives the request out.
- R11: Synchronous reset clears the request and the pending flag, and sets the stored previous result to false.
- R12: `irq_req` is registered. It goes to 1 at the same clock edge that first samples the true condition (when `sync_fetch`=0 and `irq_en`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | WIDTH | Port pin values |
| out_val | input | WIDTH | Port output register contents |
| dir_in | input | WIDTH | Per-line direction: 1 selects the pin, 0 selects the output register |
| mask | input | WIDTH | Per-line exclusion: 1 excludes the line |
| level_high | input | 1 | Active level: 1 is high, 0 is low |
| all_mode | input | 1 | Combine: 1 requires all lines, 0 requires any line |
| irq_en | input | 1 | Request enable |
| clr_pend | input | 1 | One-cycle pulse that drops the pending request |
| sync_fetch | input | 1 | Fetch-cycle sync from the processor; freezes the request |
| irq_req | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that every control input is synchronous to `clk` and holds a known value in every cycle once reset is released. They also assume that `clr_pend` and `sync_fetch` are level signals sampled at each edge. The bench drives all inputs at the falling edge from a single initial process and keeps them defined from time zero. It asserts reset for several cycles before any condition is presented, so the stored previous result starts from a known false value.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    COMBINE_ANY = 1'b0,
    COMBINE_ALL = 1'b1
  } combine_e;
endpackage

// File: rtl/pm_line_eval.sv
module pm_line_eval #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] out_val,
  input  logic [WIDTH-1:0] dir_in,
  input  logic [WIDTH-1:0] mask,
  input  logic             level_high,
  output logic [WIDTH-1:0] hit,
  output logic [WIDTH-1:0] live
);
  // Per-line evaluation: pick the source, compare against the active level,
  // and qualify with the mask.
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic eff;
    assign eff     = dir_in[i] ? pin_in[i] : out_val[i];
    assign live[i] = ~mask[i];
    assign hit[i]  = live[i] & (eff == level_high);
  end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
  import pm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] hit,
  input  logic [WIDTH-1:0] live,
  input  combine_e         mode,
  output logic             cond
);
  logic any_live;
  logic all_hit;
  logic any_hit;

  assign any_live = |live;
  assign any_hit  = |hit;
  assign all_hit  = ((hit & live) == live);

  always_comb begin
    unique case (mode)
      COMBINE_ALL: cond = any_live & all_hit;
      default:     cond = any_hit;
    endcase
  end
endmodule

// File: rtl/pm_edge_req.sv
module pm_edge_req (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic irq_en,
  input  logic clr_pend,
  input  logic sync_fetch,
  output logic irq_req
);
  logic cond_q;
  logic pend_q;
  logic pend_d;
  logic rise;
  logic irq_q;

  assign rise = cond & ~cond_q;

  always_comb begin
    pend_d = pend_q;
    if (rise)     pend_d = 1'b1;
    if (clr_pend) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      pend_q <= pend_d;
      if (!sync_fetch) irq_q <= pend_d & irq_en;
    end
  end

  assign irq_req = irq_q;

  // R8: request frozen while the fetch sync is asserted
  a_r8_sync_hold: assert property (@(posedge clk) disable iff (rst)
    sync_fetch |=> $stable(irq_req));

  // R9: a clear outside the sync window drops the request
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && !sync_fetch) |=> !irq_req);

  // R10: disabled enable keeps the output low
  a_r10_enable_gate: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !sync_fetch) |=> !irq_req);

  // R5: a new request rises only if the condition was observed true
  a_r5_rise_needs_cond: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !sync_fetch && !pend_q && !cond) |=> !irq_req);
endmodule

// File: rtl/pattern_irq_detect.sv
module pattern_irq_detect
  import pm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] out_val,
  input  logic [WIDTH-1:0] dir_in,
  input  logic [WIDTH-1:0] mask,
  input  logic             level_high,
  input  logic             all_mode,
  input  logic             irq_en,
  input  logic             clr_pend,
  input  logic             sync_fetch,
  output logic             irq_req
);
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] live;
  logic             cond;
  combine_e         mode;

  assign mode = all_mode ? COMBINE_ALL : COMBINE_ANY;

  pm_line_eval #(.WIDTH(WIDTH)) u_eval (
    .pin_in     (pin_in),
    .out_val    (out_val),
    .dir_in     (dir_in),
    .mask       (mask),
    .level_high (level_high),
    .hit        (hit),
    .live       (live)
  );

  pm_combine #(.WIDTH(WIDTH)) u_comb (
    .hit  (hit),
    .live (live),
    .mode (mode),
    .cond (cond)
  );

  pm_edge_req u_req (
    .clk        (clk),
    .rst        (rst),
    .cond       (cond),
    .irq_en     (irq_en),
    .clr_pend   (clr_pend),
    .sync_fetch (sync_fetch),
    .irq_req    (irq_req)
  );

  // R7: fully masked port yields a false condition
  a_r7_full_mask: assert property (@(posedge clk) disable iff (rst)
    (&mask) |-> !cond);

  // R1: masked lines never report a hit
  a_r1_masked_no_hit: assert property (@(posedge clk) disable iff (rst)
    (hit & mask) == '0);
endmodule

// File: tb/pattern_irq_detect_tb.sv
module pattern_irq_detect_tb;
  localparam int W = 8;
  localparam int NV = 20;
  // {pin[19:12], mask[11:4], all[3], high[2], clr[1], expected irq[0]}
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 idle false
    {8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 any rise, R12
    {8'h03, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},  // R9 clear
    {8'h03, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 no refire
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 masked line
    {8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 still true
    {8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 low false
    {8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 low rise
    {8'hFE, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h0F, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 true, no rise
    {8'h07, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 partial false
    {8'h0F, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 all rise
    {8'h0F, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0},  // R7 all masked
    {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 any masked
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 R4 all-low rise
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pin_in = '0, out_val = '0, dir_in = '1, mask = '1;
  logic level_high = 1'b1, all_mode = 1'b0, irq_en = 1'b1;
  logic clr_pend = 1'b0, sync_fetch = 1'b0;
  logic irq_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pattern_irq_detect #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .out_val(out_val),
    .dir_in(dir_in), .mask(mask), .level_high(level_high),
    .all_mode(all_mode), .irq_en(irq_en), .clr_pend(clr_pend),
    .sync_fetch(sync_fetch), .irq_req(irq_req)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%b expected=%b", tag, irq_req, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    pin_in = 8'h01; mask = 8'h00;
    repeat (3) tick();
    check(1'b0, "R11 reset holds request low");
    rst = 1'b0; pin_in = 8'h00;
    tick();
    check(1'b0, "R11 after release");

    for (int i = 0; i < NV; i++) begin
      pin_in   = VEC[i][19:12];
      mask     = VEC[i][11:4];
      all_mode = VEC[i][3];
      level_high = VEC[i][2];
      clr_pend = VEC[i][1];
      tick();
      check(VEC[i][0], $sformatf("R1-table vector %0d (R2 R3 R4 R5 R7 R9 R12)", i));
    end
    clr_pend = 1'b0;

    // R6: output-direction line taken from out_val
    all_mode = 1'b0; level_high = 1'b1;
    dir_in = 8'hFE; mask = 8'hFE; pin_in = 8'hFF; out_val = 8'h00;
    tick(); check(1'b0, "R6 pin ignored on output line");
    out_val = 8'h01;
    tick(); check(1'b1, "R6 out_val drives condition");
    clr_pend = 1'b1; tick(); clr_pend = 1'b0;
    check(1'b0, "R9 clear after R6");
    out_val = 8'h00; dir_in = 8'hFF; pin_in = 8'h00;
    tick(); check(1'b0, "R6 back to false");

    // R8: deferral during sync
    sync_fetch = 1'b1; pin_in = 8'h01;
    tick(); check(1'b0, "R8 rise deferred");
    tick(); check(1'b0, "R8 still deferred");
    sync_fetch = 1'b0;
    tick(); check(1'b1, "R8 released after sync");
    sync_fetch = 1'b1; clr_pend = 1'b1;
    tick(); clr_pend = 1'b0;
    check(1'b1, "R8 clear frozen during sync");
    sync_fetch = 1'b0;
    tick(); check(1'b0, "R8 clear applied after sync");

    // R10: enable gating
    pin_in = 8'h00; tick();
    irq_en = 1'b0; pin_in = 8'h01;
    tick(); check(1'b0, "R10 disabled holds low");
    tick(); check(1'b0, "R10 still low");
    irq_en = 1'b1;
    tick(); check(1'b1, "R10 pending appears on enable");

    // R11: mid-run reset clears request and previous result
    rst = 1'b1;
    tick(); check(1'b0, "R11 mid-run reset");
    rst = 1'b0;
    tick(); check(1'b1, "R11 previous result cleared, true condition rises");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule